// File: doc/BRIEF.md
# Configurable multiply add-subtract unit

This block multiplies two operands at full precision and then adds the product to a third operand, or subtracts it. Each clock it can take a fresh operand set. A run-time select line picks the operation: the result is either `acc_in + mul_x * mul_y` or `acc_in - mul_x * mul_y`. Parameters fix whether each operand is read as a two's-complement value or as an unsigned value. The product is never truncated. The addend joins the product with their least significant bits aligned. All of this takes place in an internal result of `SUM_W = max(A_W+B_W+2, C_W+1) + 1` bits, which is 50 bits at the default sizes.

The full internal result is driven out on `chain_out`, so the next unit in a chain can take it. `res` carries a window of that result, picked by `OUT_HI`/`OUT_LO`. A parameter can switch the addend source from `acc_in` to the incoming chain value `chain_in`.

There are two latency settings, one for the multiplier path and one for the addend path. When both are 0, the block is purely combinational. Otherwise it is a three-stage pipeline that accepts new operands every cycle. The pipeline has an active-high enable and an active-high synchronous clear, and a parameter sets which of the two wins.

Top module: `muladd_unit`

## Requirements
- R1: While `rst_n` is low, a pipelined instance drives 0 on `res` and `chain_out`.
- R2: With `sub_sel` = 0 the result is addend + product. With `sub_sel` = 1 it is addend - product. The product is at full precision, the LSBs are aligned, and the result is two's complement modulo 2^SUM_W.
- R3: `A_UNS`, `B_UNS` and `C_UNS` each set how their operand is read: 0 means signed and 1 means unsigned. This holds at the extreme values of every operand.
- R4: `res` equals bits `OUT_HI` down to `OUT_LO` of the internal result. `chain_out` carries all SUM_W bits.
- R5: With `CASCADE_EN` = 1, the addend is `chain_in`, read as a signed SUM_W-bit value, and `acc_in` has no effect. With `CASCADE_EN` = 0, `chain_in` has no effect.
- R6: With `CLR_NEEDS_EN` = 0, `clr` high at a clock edge zeroes every pipeline register, whatever the state of `en`.
- R7: With `CLR_NEEDS_EN` = 1, `clr` acts only in cycles where `en` is high. With `en` low, the registers keep their values.
- R8: With `en` low, and no clear that applies under R6/R7, every pipeline register holds.
- R9: A pipelined instance delivers an operand set on `chain_out` three enabled edges after it is presented, on the multiplier path and on the addend path alike. It accepts a new set at every enabled edge, and a clear leaves zeros in flight for two more edges.
- R10: If either `AB_PIPE` or `C_PIPE` is 1, both paths take the three-stage latency.
- R11: With `AB_PIPE` = `C_PIPE` = 0, the outputs follow the inputs in the same cycle, and `en` and `clr` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Pipeline enable, active high |
| clr | input | 1 | Synchronous clear, active high |
| mul_x | input | A_W | First multiplier operand |
| mul_y | input | B_W | Second multiplier operand |
| acc_in | input | C_W | Addend operand |
| chain_in | input | SUM_W | Chain addend, used in place of `acc_in` when `CASCADE_EN` = 1 |
| sub_sel | input | 1 | 0 = add product, 1 = subtract product |
| res | output | OUT_HI-OUT_LO+1 | Selected bit window of the result |
| chain_out | output | SUM_W | Full-width result |

## Verification
Two things can fall in the same cycle: a clear and a low enable. The bench provokes this by raising `clr` while `en` is low, with live data in flight. It does so on one instance where the clear wins and on one where the enable gates it. The first instance must show zeros. The second must hold the values it had in flight, and both are judged against a behavioural model that steps each stage every clock. The bench also covers a clear arriving while the product of a previous operand set is still in the pipeline, and checks that the zeros flush through before new data appears.

// File: rtl/muladd_pkg.sv
package muladd_pkg;

  function automatic int imax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  // Internal result width: the product carries one extra bit per operand
  // so that mixed signed/unsigned factors fit, and the addend gets one
  // extra bit for an unsigned top bit; one more bit absorbs the carry.
  function automatic int sum_width(input int aw, input int bw, input int cw);
    return imax(aw + bw + 2, cw + 1) + 1;
  endfunction

endpackage

// File: rtl/muladd_extend.sv
module muladd_extend #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 9,
  parameter bit UNS   = 1'b0
) (
  input  logic [IN_W-1:0]  x,
  output logic [OUT_W-1:0] y
);
  localparam int PAD = OUT_W - IN_W;

  generate
    if (UNS) begin : g_zero
      assign y = {{PAD{1'b0}}, x};
    end else begin : g_sign
      assign y = {{PAD{x[IN_W-1]}}, x};
    end
  endgenerate
endmodule

// File: rtl/muladd_stage.sv
module muladd_stage #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         zap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      logic [W-1:0] q_nx;

      always_comb begin
        q_nx = q_r;
        if (zap)     q_nx = '0;
        else if (ld) q_nx = d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nx;
      end

      assign q = q_r;
    end else begin : g_wire
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst_n, ld, zap};
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/muladd_addsub.sv
module muladd_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] addend,
  input  logic [W-1:0] prod,
  input  logic         sub,
  output logic [W-1:0] sum
);
  always_comb begin
    if (sub) sum = addend - prod;
    else     sum = addend + prod;
  end
endmodule

// File: rtl/muladd_rst_sync.sv
module muladd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic ff1;
  logic ff2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1 <= 1'b0;
      ff2 <= 1'b0;
    end else begin
      ff1 <= 1'b1;
      ff2 <= ff1;
    end
  end

  assign rst_q = ff2;
endmodule

// File: rtl/muladd_unit.sv
module muladd_unit #(
  parameter int A_W          = 18,
  parameter int B_W          = 18,
  parameter int C_W          = 48,
  parameter bit A_UNS        = 1'b0,
  parameter bit B_UNS        = 1'b0,
  parameter bit C_UNS        = 1'b0,
  parameter int OUT_HI       = 47,
  parameter int OUT_LO       = 0,
  parameter bit CASCADE_EN   = 1'b0,
  parameter bit CLR_NEEDS_EN = 1'b0,
  parameter bit AB_PIPE      = 1'b1,
  parameter bit C_PIPE       = 1'b1,
  localparam int SUM_W       = muladd_pkg::sum_width(A_W, B_W, C_W),
  localparam int P_W         = OUT_HI - OUT_LO + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [A_W-1:0]   mul_x,
  input  logic [B_W-1:0]   mul_y,
  input  logic [C_W-1:0]   acc_in,
  input  logic [SUM_W-1:0] chain_in,
  input  logic             sub_sel,
  output logic [P_W-1:0]   res,
  output logic [SUM_W-1:0] chain_out
);
  // Either latency setting pipelines both paths (R10).
  localparam bit PIPE  = AB_PIPE | C_PIPE;
  localparam int AX_W  = A_W + 1;
  localparam int BX_W  = B_W + 1;
  localparam int MUL_W = A_W + B_W + 2;
  localparam int S1_W  = AX_W + BX_W + SUM_W + 1;
  localparam int S2_W  = 2 * SUM_W + 1;

  logic rst_q;
  logic clr_eff;
  logic unused_opnd;

  muladd_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  // Clear priority: clear alone, or clear qualified by enable (R6, R7).
  assign clr_eff = clr & (CLR_NEEDS_EN ? en : 1'b1);
  assign unused_opnd = ^{acc_in, chain_in};

  // Operand extension to signed internal forms (R3).
  logic [AX_W-1:0]  a_x;
  logic [BX_W-1:0]  b_x;
  logic [SUM_W-1:0] c_x;
  logic [SUM_W-1:0] add_x;

  muladd_extend #(.IN_W(A_W), .OUT_W(AX_W), .UNS(A_UNS)) u_ext_a (
    .x (mul_x), .y (a_x)
  );
  muladd_extend #(.IN_W(B_W), .OUT_W(BX_W), .UNS(B_UNS)) u_ext_b (
    .x (mul_y), .y (b_x)
  );
  muladd_extend #(.IN_W(C_W), .OUT_W(SUM_W), .UNS(C_UNS)) u_ext_c (
    .x (acc_in), .y (c_x)
  );

  // Addend source select (R5).
  generate
    if (CASCADE_EN) begin : g_chain
      assign add_x = chain_in;
    end else begin : g_local
      assign add_x = c_x;
    end
  endgenerate

  // Stage 1: operands, addend and operation select.
  logic [S1_W-1:0]  s1_d;
  logic [S1_W-1:0]  s1_q;
  logic [AX_W-1:0]  s1_a;
  logic [BX_W-1:0]  s1_b;
  logic [SUM_W-1:0] s1_add;
  logic             s1_sub;

  assign s1_d = {a_x, b_x, add_x, sub_sel};

  muladd_stage #(.W(S1_W), .EN(PIPE)) u_s1 (
    .clk (clk), .rst_n (rst_q), .ld (en), .zap (clr_eff),
    .d   (s1_d), .q (s1_q)
  );

  assign {s1_a, s1_b, s1_add, s1_sub} = s1_q;

  // Full-precision signed product (R2).
  logic signed [MUL_W-1:0] mul_c;
  logic [SUM_W-1:0]        prod_x;

  assign mul_c = $signed(s1_a) * $signed(s1_b);

  muladd_extend #(.IN_W(MUL_W), .OUT_W(SUM_W), .UNS(1'b0)) u_ext_p (
    .x (mul_c), .y (prod_x)
  );

  // Stage 2: product with its delayed addend and select.
  logic [S2_W-1:0]  s2_d;
  logic [S2_W-1:0]  s2_q;
  logic [SUM_W-1:0] s2_prod;
  logic [SUM_W-1:0] s2_add;
  logic             s2_sub;

  assign s2_d = {prod_x, s1_add, s1_sub};

  muladd_stage #(.W(S2_W), .EN(PIPE)) u_s2 (
    .clk (clk), .rst_n (rst_q), .ld (en), .zap (clr_eff),
    .d   (s2_d), .q (s2_q)
  );

  assign {s2_prod, s2_add, s2_sub} = s2_q;

  // Add or subtract, then the output stage.
  logic [SUM_W-1:0] sum_c;

  muladd_addsub #(.W(SUM_W)) u_addsub (
    .addend (s2_add),
    .prod   (s2_prod),
    .sub    (s2_sub),
    .sum    (sum_c)
  );

  muladd_stage #(.W(SUM_W), .EN(PIPE)) u_s3 (
    .clk (clk), .rst_n (rst_q), .ld (en), .zap (clr_eff),
    .d   (sum_c), .q (chain_out)
  );

  // Output window (R4).
  assign res = chain_out[OUT_HI:OUT_LO];
endmodule

// File: rtl/muladd_unit_chk.sv
module muladd_unit_chk #(
  parameter int SUM_W        = 50,
  parameter int P_W          = 48,
  parameter bit PIPE         = 1'b1,
  parameter bit CLR_NEEDS_EN = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             clr,
  input logic [P_W-1:0]   res,
  input logic [SUM_W-1:0] chain_out
);
  logic clr_hit;
  assign clr_hit = clr && (en || !CLR_NEEDS_EN);

  generate
    if (PIPE) begin : g_chk
      assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (chain_out == '0) && (res == '0));

      assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> (chain_out == '0) && (res == '0));

      assert_gated_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (CLR_NEEDS_EN && clr && !en) |=> $stable(chain_out));

      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && (CLR_NEEDS_EN || !clr)) |=> ($stable(chain_out) && $stable(res)));

      assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_hit, 2) |=> (chain_out == '0));
    end
  endgenerate
endmodule

bind muladd_unit muladd_unit_chk #(
  .SUM_W        (SUM_W),
  .P_W          (P_W),
  .PIPE         (AB_PIPE | C_PIPE),
  .CLR_NEEDS_EN (CLR_NEEDS_EN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .clr       (clr),
  .res       (res),
  .chain_out (chain_out)
);

// File: tb/muladd_unit_test.sv
`timescale 1ns/1ps
module muladd_unit_test;
  localparam int SW = 50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          clr = 1'b0;
  logic          sub_sel = 1'b0;
  logic [17:0]   mx = '0;
  logic [17:0]   my = '0;
  logic [47:0]   acc = '0;
  logic [SW-1:0] chin = '0;

  logic [47:0]   res0;
  logic [SW-1:0] co0;
  logic [32:0]   res1;
  logic [SW-1:0] co1;
  logic [47:0]   res2;
  logic [SW-1:0] co2;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Main: all signed, local addend, clear wins over enable.
  muladd_unit uut (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .mul_x(mx), .mul_y(my),
    .acc_in(acc), .chain_in(chin), .sub_sel(sub_sel), .res(res0), .chain_out(co0)
  );

  // Alt: unsigned mul_x, chain addend, enable-gated clear, window 40:8,
  // only the addend path set pipelined (R10).
  muladd_unit #(.A_UNS(1'b1), .CASCADE_EN(1'b1), .CLR_NEEDS_EN(1'b1),
                .OUT_HI(40), .OUT_LO(8), .AB_PIPE(1'b0), .C_PIPE(1'b1)) uut_alt (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .mul_x(mx), .mul_y(my),
    .acc_in(acc), .chain_in(chin), .sub_sel(sub_sel), .res(res1), .chain_out(co1)
  );

  // Comb: unsigned mul_y and acc_in, no pipeline (R11).
  muladd_unit #(.B_UNS(1'b1), .C_UNS(1'b1), .AB_PIPE(1'b0), .C_PIPE(1'b0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .mul_x(mx), .mul_y(my),
    .acc_in(acc), .chain_in(chin), .sub_sel(sub_sel), .res(res2), .chain_out(co2)
  );

  always #2 clk = ~clk;

  function automatic longint ext(input longint raw, input int w, input bit uns);
    longint v;
    v = raw & ((64'sd1 <<< w) - 1);
    if (!uns && v[w-1]) v = v - (64'sd1 <<< w);
    return v;
  endfunction

  function automatic longint wrap(input longint v);
    return v & ((64'sd1 <<< SW) - 1);
  endfunction

  // Behavioural model of the two pipelined instances.
  longint m1a[2], m1b[2], m1c[2], m2p[2], m2c[2], m3[2];
  bit     m1s[2], m2s[2];
  int     rcnt;
  bit     prio[2] = '{1'b0, 1'b1};
  bit     aun[2]  = '{1'b0, 1'b1};
  bit     casc[2] = '{1'b0, 1'b1};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt = 0;
      for (int i = 0; i < 2; i++) begin
        m1a[i] = 0; m1b[i] = 0; m1c[i] = 0; m2p[i] = 0; m2c[i] = 0; m3[i] = 0;
        m1s[i] = 0; m2s[i] = 0;
      end
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (clr && (prio[i] ? en : 1'b1)) begin
          m1a[i] = 0; m1b[i] = 0; m1c[i] = 0; m2p[i] = 0; m2c[i] = 0; m3[i] = 0;
          m1s[i] = 0; m2s[i] = 0;
        end else if (en) begin
          m3[i]  = wrap(m2s[i] ? m2c[i] - m2p[i] : m2c[i] + m2p[i]);
          m2p[i] = m1a[i] * m1b[i];
          m2c[i] = m1c[i];
          m2s[i] = m1s[i];
          m1a[i] = ext(longint'(mx), 18, aun[i]);
          m1b[i] = ext(longint'(my), 18, 1'b0);
          m1c[i] = casc[i] ? ext(longint'(chin), SW, 1'b0) : ext(longint'(acc), 48, 1'b0);
          m1s[i] = sub_sel;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    longint e2;
    chk(tag, "main chain_out", {14'b0, co0}, m3[0]);
    chk("R4", "main res window", {16'b0, res0}, m3[0] & 64'hFFFF_FFFF_FFFF);
    chk({tag, "/R10"}, "alt chain_out", {14'b0, co1}, m3[1]);
    chk("R4", "alt res window", {31'b0, res1}, (m3[1] >> 8) & 64'h1_FFFF_FFFF);
    e2 = ext(longint'(mx), 18, 1'b0) * ext(longint'(my), 18, 1'b1);
    e2 = wrap(sub_sel ? ext(longint'(acc), 48, 1'b1) - e2 : ext(longint'(acc), 48, 1'b1) + e2);
    chk("R11", "comb chain_out", {14'b0, co2}, e2);
    chk("R11/R4", "comb res", {16'b0, res2}, e2 & 64'hFFFF_FFFF_FFFF);
  endtask

  task automatic rnd_ops();
    mx   = 18'($urandom);
    my   = 18'($urandom);
    acc  = 48'({$urandom, $urandom});
    chin = SW'({$urandom, $urandom});
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset with enable high and live operands.
    en = 1'b1; rnd_ops();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); compare("R1"); rnd_ops();
    end
    rst_n = 1'b1; en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); compare("R1");
    end

    // R2/R9: streaming random operands, mixed add and subtract.
    en = 1'b1;
    for (int k = 0; k < 60; k++) begin
      rnd_ops(); sub_sel = 1'($urandom);
      @(negedge clk); compare("R2/R9");
    end

    // R3: extreme operand values under each interpretation.
    for (int k = 0; k < 16; k++) begin
      mx  = k[0] ? 18'h20000 : 18'h3FFFF;
      my  = k[1] ? 18'h20000 : 18'h1FFFF;
      acc = k[2] ? 48'h8000_0000_0000 : 48'hFFFF_FFFF_FFFF;
      chin = k[2] ? {1'b1, 49'b0} : {1'b0, {49{1'b1}}};
      sub_sel = k[3];
      @(negedge clk); compare("R3");
    end

    // R5: chain_in varies with the other operands fixed.
    mx = 18'h00123; my = 18'h3FF00; acc = 48'h0000_1234_5678; sub_sel = 1'b0;
    for (int k = 0; k < 12; k++) begin
      chin = SW'({$urandom, $urandom});
      @(negedge clk); compare("R5");
    end
    chin = '0;
    for (int k = 0; k < 8; k++) begin
      acc = 48'({$urandom, $urandom});
      @(negedge clk); compare("R5");
    end

    // R8: enable toggling randomly.
    for (int k = 0; k < 40; k++) begin
      rnd_ops(); sub_sel = 1'($urandom); en = 1'($urandom);
      @(negedge clk); compare("R8");
    end

    // R6: clear with enable high, data in flight.
    en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      rnd_ops(); @(negedge clk); compare("R6");
    end
    clr = 1'b1; rnd_ops();
    @(negedge clk); compare("R6");
    clr = 1'b0;
    for (int k = 0; k < 5; k++) begin
      rnd_ops(); @(negedge clk); compare("R6/R9");
    end

    // R7: clear with enable low; main clears, alt holds.
    for (int k = 0; k < 4; k++) begin
      rnd_ops(); @(negedge clk); compare("R7");
    end
    en = 1'b0; clr = 1'b1; rnd_ops();
    @(negedge clk); compare("R7");
    @(negedge clk); compare("R7");
    clr = 1'b0; en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      rnd_ops(); @(negedge clk); compare("R7/R9");
    end

    // Mixed enable and clear at random.
    for (int k = 0; k < 200; k++) begin
      rnd_ops(); sub_sel = 1'($urandom);
      en = ($urandom % 4) != 0; clr = ($urandom % 10) == 0;
      @(negedge clk); compare("R6/R7/R8");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule